// File: doc/BRIEF.md
# Shift and Rotate Unit with Carry

This block is an execution unit that shifts or rotates a held operand and keeps a carry bit beside it. It provides logical shifts left and right, an arithmetic right shift that keeps the sign, plain rotates in both directions and rotates in both directions that pass through the carry. After each operation the carry holds the last bit that left the operand. The operand and the carry live in registers. A load port seeds them, and a chain of operations then works on the running value, one operation per clock.

The shift distance comes from one of three sources: a fixed distance of one, an immediate field, or the value of a designated count register that the surrounding pipeline presents on a port. Only the low five bits of the chosen count are used. For the rotates through carry, that distance is further reduced modulo the operand width plus one. A distance that masks to zero changes neither the operand nor the carry.

Top module: `shrot_unit`

## Requirements
- R1: After reset the operand register `resultOut` is 0 and `carryOut` is 0.
- R2: When `loadIn` is high, on the next edge `resultOut` takes `loadValue` and `carryOut` takes `loadCarry`. This takes priority over `validIn` in the same cycle.
- R3: `opSel` 3'b100 and 3'b110 both shift left with zero fill, and the carry receives the last bit shifted out. A distance greater than the width gives result 0 and carry 0.
- R4: `opSel` 3'b101 shifts right with zero fill, and the carry receives the last bit shifted out (for a distance equal to the width, the old most significant bit).
- R5: `opSel` 3'b111 shifts right and copies the sign bit into the vacated positions, with the carry taking the last bit shifted out. 0xFF by 1 stays 0xFF with carry 1. A distance of at least the width fills every bit with the sign and sets the carry to the sign.
- R6: `opSel` 3'b000 rotates left and 3'b001 rotates right, both by the distance modulo the width. The carry becomes the new least significant bit after a left rotate, and the new most significant bit after a right rotate.
- R7: `opSel` 3'b010 rotates left and 3'b011 rotates right through the carry, treated as one (width+1)-bit value with the carry above the operand's most significant bit. The rotation distance is the masked count modulo width+1.
- R8: `countSrc` 2'b00 selects a distance of 1, 2'b01 selects `countImm`, and 2'b10 or 2'b11 selects `countReg`. Only the low 5 bits of the chosen value are used.
- R9: An operation whose masked distance is 0 leaves `resultOut` and `carryOut` unchanged.
- R10: While `validIn` and `loadIn` are both low, `resultOut` and `carryOut` hold their values, whatever the other inputs do.
- R11: An operation requested with `validIn` completes in one clock: result and carry both change on the edge that samples `validIn`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| loadIn | input | 1 | Seed operand and carry |
| loadValue | input | WIDTH | Operand value to seed |
| loadCarry | input | 1 | Carry value to seed |
| validIn | input | 1 | Perform the selected operation this cycle |
| opSel | input | 3 | Operation code (see R3 to R7) |
| countSrc | input | 2 | Distance source select (see R8) |
| countImm | input | SRC_W | Immediate distance |
| countReg | input | SRC_W | Count register value |
| resultOut | output | WIDTH | Held operand |
| carryOut | output | 1 | Held carry |

## Verification
The hardest cases to reach from the ports are the distances whose raw value is nonzero but which mask to zero, or which reduce through the modulo-nine step to a full turn of the carry rotation. The bench drives immediates and count-register values with upper bits set (0x20, 0x40, 0x24) and carry-rotation distances of 9 and 10. It also builds chained sequences from a known seed, so that the carry left by one operation feeds the next one. Load and operation requests in the same cycle, and stretches with neither request, are applied directly to confirm priority and hold.

// File: rtl/shrot_pkg.sv
package shrot_pkg;
  parameter int COUNT_BITS = 5;

  typedef enum logic [2:0] {
    OP_ROL = 3'b000,
    OP_ROR = 3'b001,
    OP_RCL = 3'b010,
    OP_RCR = 3'b011,
    OP_SHL = 3'b100,
    OP_SHR = 3'b101,
    OP_SAL = 3'b110,
    OP_SAR = 3'b111
  } opCodeT;

  typedef enum logic [2:0] {
    K_LEFT  = 3'd0,
    K_RIGHT = 3'd1,
    K_ARITH = 3'd2,
    K_ROTL  = 3'd3,
    K_ROTR  = 3'd4,
    K_RCL   = 3'd5,
    K_RCR   = 3'd6
  } kindT;

  typedef struct packed {
    logic                  load;
    logic                  exec;
    kindT                  kind;
    logic [COUNT_BITS-1:0] amount;
  } strobeT;
endpackage

// File: rtl/shrot_ctrl.sv
module shrot_ctrl
  import shrot_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int SRC_W = 8
) (
  input  logic             loadIn,
  input  logic             validIn,
  input  logic [2:0]       opSel,
  input  logic [1:0]       countSrc,
  input  logic [SRC_W-1:0] countImm,
  input  logic [SRC_W-1:0] countReg,
  output strobeT           strobe
);
  localparam int RC_MOD = WIDTH + 1;

  logic [SRC_W-1:0]      rawCount;
  logic [COUNT_BITS-1:0] maskedCount;
  logic [COUNT_BITS-1:0] rcCount;
  kindT                  kindSel;
  int                    modTmp;

  always_comb begin
    unique case (countSrc)
      2'b00:   rawCount = SRC_W'(1);
      2'b01:   rawCount = countImm;
      default: rawCount = countReg;
    endcase
    maskedCount = rawCount[COUNT_BITS-1:0];
    modTmp      = int'(maskedCount) % RC_MOD;
    rcCount     = COUNT_BITS'(modTmp);
  end

  always_comb begin
    unique case (opCodeT'(opSel))
      OP_ROL:  kindSel = K_ROTL;
      OP_ROR:  kindSel = K_ROTR;
      OP_RCL:  kindSel = K_RCL;
      OP_RCR:  kindSel = K_RCR;
      OP_SHL:  kindSel = K_LEFT;
      OP_SAL:  kindSel = K_LEFT;
      OP_SHR:  kindSel = K_RIGHT;
      default: kindSel = K_ARITH;
    endcase
  end

  always_comb begin
    strobe.load   = loadIn;
    strobe.exec   = validIn && !loadIn && (maskedCount != '0);
    strobe.kind   = kindSel;
    strobe.amount = (kindSel == K_RCL || kindSel == K_RCR) ? rcCount : maskedCount;
  end

  // R7: carry-rotation distance stays below one full turn of width+1 bits
  always_comb begin
    if (strobe.exec && (strobe.kind == K_RCL || strobe.kind == K_RCR))
      assert_rc_range_R7: assert (int'(strobe.amount) < RC_MOD);
  end
endmodule

// File: rtl/shrot_datapath.sv
module shrot_datapath
  import shrot_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobeT           strobe,
  input  logic [WIDTH-1:0] loadValue,
  input  logic             loadCarry,
  output logic [WIDTH-1:0] resultQ,
  output logic             carryQ
);
  localparam int EXT = 1 << COUNT_BITS;
  localparam int LW  = WIDTH + EXT;

  logic [LW-1:0]          leftWide;
  logic [LW-1:0]          rightWide;
  logic signed [LW-1:0]   arithWide;
  logic [2*WIDTH-1:0]     rolWide;
  logic [2*WIDTH-1:0]     rorWide;
  logic [WIDTH:0]         nineQ;
  logic [2*WIDTH+1:0]     rclWide;
  logic [2*WIDTH+1:0]     rcrWide;
  logic [COUNT_BITS-1:0]  rotAmt;
  logic [WIDTH-1:0]       nextRes;
  logic                   nextCarry;
  int                     rotTmp;

  always_comb begin
    rotTmp    = int'(strobe.amount) % WIDTH;
    rotAmt    = COUNT_BITS'(rotTmp);
    leftWide  = {{EXT{1'b0}}, resultQ} << strobe.amount;
    rightWide = {resultQ, {EXT{1'b0}}} >> strobe.amount;
    arithWide = $signed({resultQ, {EXT{1'b0}}}) >>> strobe.amount;
    rolWide   = {resultQ, resultQ} << rotAmt;
    rorWide   = {resultQ, resultQ} >> rotAmt;
    nineQ     = {carryQ, resultQ};
    rclWide   = {nineQ, nineQ} << strobe.amount;
    rcrWide   = {nineQ, nineQ} >> strobe.amount;
  end

  always_comb begin
    nextRes   = resultQ;
    nextCarry = carryQ;
    unique case (strobe.kind)
      K_LEFT: begin
        nextRes   = leftWide[WIDTH-1:0];
        nextCarry = leftWide[WIDTH];
      end
      K_RIGHT: begin
        nextRes   = rightWide[LW-1:EXT];
        nextCarry = rightWide[EXT-1];
      end
      K_ARITH: begin
        nextRes   = arithWide[LW-1:EXT];
        nextCarry = arithWide[EXT-1];
      end
      K_ROTL: begin
        nextRes   = rolWide[2*WIDTH-1:WIDTH];
        nextCarry = rolWide[WIDTH];
      end
      K_ROTR: begin
        nextRes   = rorWide[WIDTH-1:0];
        nextCarry = rorWide[WIDTH-1];
      end
      K_RCL: begin
        nextRes   = rclWide[2*WIDTH:WIDTH+1];
        nextCarry = rclWide[2*WIDTH+1];
      end
      K_RCR: begin
        nextRes   = rcrWide[WIDTH-1:0];
        nextCarry = rcrWide[WIDTH];
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resultQ <= '0;
      carryQ  <= 1'b0;
    end else if (strobe.load) begin
      resultQ <= loadValue;
      carryQ  <= loadCarry;
    end else if (strobe.exec) begin
      resultQ <= nextRes;
      carryQ  <= nextCarry;
    end
  end

  assert_load_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> (resultQ == $past(loadValue)) && (carryQ == $past(loadCarry)));

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.load && !strobe.exec) |=> $stable(resultQ) && $stable(carryQ));

  assert_sign_kept_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.exec && strobe.kind == K_ARITH) |=> resultQ[WIDTH-1] == $past(resultQ[WIDTH-1]));

  assert_rol_carry_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.exec && strobe.kind == K_ROTL) |=> carryQ == resultQ[0]);

  assert_flush_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.exec && strobe.kind == K_LEFT && int'(strobe.amount) > WIDTH)
      |=> (resultQ == '0) && !carryQ);
endmodule

// File: rtl/shrot_unit.sv
module shrot_unit
  import shrot_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int SRC_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             loadIn,
  input  logic [WIDTH-1:0] loadValue,
  input  logic             loadCarry,
  input  logic             validIn,
  input  logic [2:0]       opSel,
  input  logic [1:0]       countSrc,
  input  logic [SRC_W-1:0] countImm,
  input  logic [SRC_W-1:0] countReg,
  output logic [WIDTH-1:0] resultOut,
  output logic             carryOut
);
  strobeT strobe;

  shrot_ctrl #(.WIDTH(WIDTH), .SRC_W(SRC_W)) ctrl_i (
    .loadIn   (loadIn),
    .validIn  (validIn),
    .opSel    (opSel),
    .countSrc (countSrc),
    .countImm (countImm),
    .countReg (countReg),
    .strobe   (strobe)
  );

  shrot_datapath #(.WIDTH(WIDTH)) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .loadValue (loadValue),
    .loadCarry (loadCarry),
    .resultQ   (resultOut),
    .carryQ    (carryOut)
  );

  // R9: an immediate distance masking to zero changes nothing
  assert_zero_count_R9: assert property (@(posedge clk) disable iff (!rstN)
    (validIn && !loadIn && countSrc == 2'b01 && countImm[COUNT_BITS-1:0] == '0)
      |=> $stable(resultOut) && $stable(carryOut));

  // R11: a requested nonzero-distance shift left by one of a nonzero top bit sets carry next edge
  assert_one_cycle_R11: assert property (@(posedge clk) disable iff (!rstN)
    (validIn && !loadIn && countSrc == 2'b00 && opSel == 3'b100 && resultOut[WIDTH-1])
      |=> carryOut);
endmodule

// File: tb/shrot_unit_tb_top.sv
module shrot_unit_tb_top;
  logic       clk = 1'b0;
  logic       rstN;
  logic       loadIn;
  logic [7:0] loadValue;
  logic       loadCarry;
  logic       validIn;
  logic [2:0] opSel;
  logic [1:0] countSrc;
  logic [7:0] countImm;
  logic [7:0] countReg;
  logic [7:0] resultOut;
  logic       carryOut;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  shrot_unit dut_i (
    .clk(clk), .rstN(rstN), .loadIn(loadIn), .loadValue(loadValue),
    .loadCarry(loadCarry), .validIn(validIn), .opSel(opSel),
    .countSrc(countSrc), .countImm(countImm), .countReg(countReg),
    .resultOut(resultOut), .carryOut(carryOut)
  );

  task automatic check(input string tag, input logic [7:0] expRes, input logic expC);
    checks++;
    if (resultOut !== expRes || carryOut !== expC) begin
      errors++;
      $display("FAIL %s: result=%02h carry=%0b expected result=%02h carry=%0b",
               tag, resultOut, carryOut, expRes, expC);
    end
  endtask

  task automatic seed(input logic [7:0] v, input logic c);
    @(negedge clk);
    loadIn = 1'b1; loadValue = v; loadCarry = c;
    @(negedge clk);
    loadIn = 1'b0;
  endtask

  task automatic runOp(input logic [2:0] op, input logic [1:0] src,
                       input logic [7:0] imm, input logic [7:0] creg);
    @(negedge clk);
    validIn = 1'b1; opSel = op; countSrc = src; countImm = imm; countReg = creg;
    @(negedge clk);
    validIn = 1'b0;
  endtask

  task automatic testReset();
    check("R1 reset", 8'h00, 1'b0);
  endtask

  task automatic testLogicalShifts();
    seed(8'h81, 1'b0);
    runOp(3'b100, 2'b00, 8'h00, 8'h00); check("R3 shl by1", 8'h02, 1'b1);
    runOp(3'b110, 2'b00, 8'h00, 8'h00); check("R3 sal alias", 8'h04, 1'b0);
    runOp(3'b101, 2'b00, 8'h00, 8'h00); check("R4 shr by1", 8'h02, 1'b0);
    runOp(3'b100, 2'b01, 8'h02, 8'h00); check("R8 imm 2", 8'h08, 1'b0);
    runOp(3'b100, 2'b10, 8'h00, 8'h02); check("R8 countReg 2", 8'h20, 1'b0);
    seed(8'h10, 1'b0);
    runOp(3'b100, 2'b01, 8'h24, 8'h00); check("R8 mask 0x24", 8'h00, 1'b1);
    seed(8'hFF, 1'b1);
    runOp(3'b100, 2'b01, 8'h09, 8'h00); check("R3 shl by9", 8'h00, 1'b0);
    seed(8'h81, 1'b0);
    runOp(3'b101, 2'b11, 8'h00, 8'h08); check("R4 shr by8", 8'h00, 1'b1);
  endtask

  task automatic testArith();
    seed(8'hFF, 1'b0);
    runOp(3'b110, 2'b00, 8'h00, 8'h00); check("R5 sal FF", 8'hFE, 1'b1);
    runOp(3'b111, 2'b00, 8'h00, 8'h00); check("R5 sar FE", 8'hFF, 1'b0);
    runOp(3'b111, 2'b00, 8'h00, 8'h00); check("R5 sar FF", 8'hFF, 1'b1);
    seed(8'h80, 1'b0);
    runOp(3'b111, 2'b01, 8'd20, 8'h00); check("R5 sar by20", 8'hFF, 1'b1);
    seed(8'h40, 1'b1);
    runOp(3'b111, 2'b01, 8'd3, 8'h00);  check("R5 sar positive", 8'h08, 1'b0);
  endtask

  task automatic testRotates();
    seed(8'h81, 1'b0);
    runOp(3'b000, 2'b00, 8'h00, 8'h00); check("R6 rol 81", 8'h03, 1'b1);
    runOp(3'b000, 2'b00, 8'h00, 8'h00); check("R6 rol 03", 8'h06, 1'b0);
    runOp(3'b001, 2'b01, 8'd2, 8'h00);  check("R6 ror2 06", 8'h81, 1'b1);
    runOp(3'b001, 2'b00, 8'h00, 8'h00); check("R6 ror1 81", 8'hC0, 1'b1);
    runOp(3'b000, 2'b01, 8'd8, 8'h00);  check("R6 rol by8", 8'hC0, 1'b0);
    runOp(3'b000, 2'b01, 8'd12, 8'h00); check("R6 rol by12", 8'h0C, 1'b0);
  endtask

  task automatic testCarryRotates();
    seed(8'h81, 1'b0);
    runOp(3'b010, 2'b00, 8'h00, 8'h00); check("R7 rcl 81", 8'h02, 1'b1);
    runOp(3'b010, 2'b00, 8'h00, 8'h00); check("R7 rcl 02", 8'h05, 1'b0);
    runOp(3'b011, 2'b01, 8'd2, 8'h00);  check("R7 rcr2 05", 8'h81, 1'b0);
    runOp(3'b011, 2'b00, 8'h00, 8'h00); check("R7 rcr1 81", 8'h40, 1'b1);
    runOp(3'b010, 2'b01, 8'd9, 8'h00);  check("R7 rcl by9", 8'h40, 1'b1);
    runOp(3'b010, 2'b01, 8'd10, 8'h00); check("R7 rcl by10", 8'h81, 1'b0);
  endtask

  task automatic testZeroCount();
    seed(8'h5A, 1'b1);
    runOp(3'b100, 2'b01, 8'h20, 8'h00); check("R9 imm masks to 0", 8'h5A, 1'b1);
    runOp(3'b011, 2'b10, 8'h00, 8'h40); check("R9 reg masks to 0", 8'h5A, 1'b1);
  endtask

  task automatic testHoldAndPriority();
    seed(8'h3C, 1'b0);
    @(negedge clk);
    opSel = 3'b000; countSrc = 2'b00; validIn = 1'b0; loadValue = 8'hAA; loadCarry = 1'b1;
    repeat (3) @(negedge clk);
    check("R10 idle hold", 8'h3C, 1'b0);
    @(negedge clk);
    loadIn = 1'b1; validIn = 1'b1; loadValue = 8'h11; loadCarry = 1'b1;
    opSel = 3'b100; countSrc = 2'b00;
    @(negedge clk);
    loadIn = 1'b0; validIn = 1'b0;
    check("R2 load wins", 8'h11, 1'b1);
    @(negedge clk);
    validIn = 1'b1; opSel = 3'b100; countSrc = 2'b00;
    @(posedge clk);
    #1;
    check("R11 one cycle", 8'h22, 1'b0);
    @(negedge clk);
    validIn = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rstN = 1'b0; loadIn = 1'b0; loadValue = 8'h00; loadCarry = 1'b0;
    validIn = 1'b0; opSel = 3'b000; countSrc = 2'b00; countImm = 8'h00; countReg = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    testReset();
    testLogicalShifts();
    testArith();
    testRotates();
    testCarryRotates();
    testZeroCount();
    testHoldAndPriority();
    repeat (2) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule